// File: doc/BRIEF.md
# Masked-Write GPIO Register with Input-Change Interrupt

This block is one memory-mapped 32-bit general-purpose I/O word. It serves 16 input pins and 16 output pins. A read gives two halves. The upper half holds the input pins after synchronisation. The lower half holds the output values being driven now. A write changes only the output bits whose change-enable bit is set in the upper half of the written word, so software can flip one line without a read-modify-write sequence.

Every input passes through a two-flop synchroniser. The block compares each synchronised sample with the one from the cycle before. Whenever any line differs, in either direction, it raises a one-cycle interrupt pulse. There is no per-line mask. The two lowest lines are open-drain, for use as an I2C data line (line 0) and clock line (line 1). A zero output pulls the pad low, and a one releases it. The input half always shows the real pad level, so a low reading while the output bit is one means another device is holding the line down. The other fourteen lines are push-pull.

Top module: `gpio_mask_irq`

## Requirements
- R1: While reset is held, all 16 output bits read as one. Lines 0 and 1 are released (pad_oe bits 1:0 = 0), lines 2..15 drive one, and chg_irq is 0.
- R2: bus_rdata[31:16] returns the synchronised input pins, and bus_rdata[15:0] returns the current output bits.
- R3: On a cycle with bus_wr = 1, output bit i takes bus_wdata[i] when bus_wdata[16+i] = 1 and keeps its value otherwise. The new value is visible after that clock edge.
- R4: When bus_wr = 0, the outputs do not change, whatever is on bus_wdata.
- R5: A pin change appears in bus_rdata[31:16] after exactly two rising clock edges, and not after one.
- R6: chg_irq is high for exactly one cycle, in the cycle in which the synchronised input word first shows a change. This holds for any line, for either direction, and for several lines changing together (still one pulse).
- R7: chg_irq stays 0 while the inputs are steady. This includes the cycles just after reset while the synchroniser fills, even if the pins are nonzero.
- R8: Lines 0 and 1 are open-drain. pad_o is 0 on these lines, and pad_oe is the inverse of the output bit.
- R9: Lines 2..15 are push-pull. pad_oe is 1 on these lines, and pad_o equals the output bit.
- R10: On an open-drain line, the input bit reflects the pad level even while the output bit is one (line released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 32 | Write word: [31:16] change-enable mask, [15:0] new output values |
| bus_rdata | output | 32 | Read word: [31:16] synchronised inputs, [15:0] current outputs |
| pin_in | input | 16 | Asynchronous input pins (pad level for lines 0 and 1) |
| pad_o | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable (1 = drive) |
| chg_irq | output | 1 | One-cycle pulse when any synchronised input changes |

## Verification
The bench walks every input line through a rise and a fall. For each transition it checks that nothing shows after one edge and that the new value shows after the second, which catches a design with a missing or extra synchroniser stage. It checks that the interrupt is one cycle wide and comes exactly with the change. A level-type or stretched interrupt fails here, and so does one that only watches some lines.

It holds nonzero pins through reset to catch a spurious pulse while the synchroniser fills. It sends a long pseudo-random series of masked writes, and writes with the strobe low, which would expose a write that ignores the mask or a strobe that is not honoured. It pulls the open-drain lines low while they are released, to check that the real pad level is read back and that the enable polarity is correct.

// File: rtl/gpio_mask_pkg.sv
`timescale 1ns/1ps
package gpio_mask_pkg;
    parameter int unsigned GPIO_LINES_DEF = 16;
    parameter int unsigned OD_LINES_DEF   = 2;
    parameter int unsigned SYNC_DEPTH_DEF = 2;

    typedef enum logic {
        PAD_PUSH_PULL  = 1'b0,
        PAD_OPEN_DRAIN = 1'b1
    } pad_mode_e;

    // Lines below od_lines are open-drain, the rest push-pull.
    function automatic pad_mode_e line_mode(input int unsigned idx, input int unsigned od_lines);
        return (idx < od_lines) ? PAD_OPEN_DRAIN : PAD_PUSH_PULL;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stage[0] = pin_async;
        for (int k = 1; k < DEPTH; k++) begin
            st_d.stage[k] = st_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.stage[DEPTH-1];
endmodule

// File: rtl/gpio_chg_det.sv
`timescale 1ns/1ps
module gpio_chg_det #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    output logic             chg_pulse
);
    // Compare only once the synchroniser and the previous-sample register hold real pin data.
    localparam int unsigned FILL_MAX = DEPTH + 1;
    localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

    typedef struct packed {
        logic [WIDTH-1:0]  prev;
        logic [FILL_W-1:0] fill;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    armed;

    assign armed = (st_q.fill == FILL_W'(FILL_MAX));

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        if (!armed) st_d.fill = st_q.fill + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg_pulse = armed & (|(sync_in ^ st_q.prev));
endmodule

// File: rtl/gpio_out_reg.sv
`timescale 1ns/1ps
module gpio_out_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] chg_mask,
    input  logic [WIDTH-1:0] new_val,
    output logic [WIDTH-1:0] drive
);
    typedef struct packed {
        logic [WIDTH-1:0] drive;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.drive = (st_q.drive & ~chg_mask) | (new_val & chg_mask);
        end
    end

    // All ones at reset: open-drain lines come up released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{drive: '1};
        else        st_q <= st_d;
    end

    assign drive = st_q.drive;
endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl
    import gpio_mask_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned OD_LINES = 2
) (
    input  logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (line_mode(i, OD_LINES) == PAD_OPEN_DRAIN) begin : g_od
            assign pad_o[i]  = 1'b0;
            assign pad_oe[i] = ~drive[i];
        end else begin : g_pp
            assign pad_o[i]  = drive[i];
            assign pad_oe[i] = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_mask_irq.sv
`timescale 1ns/1ps
module gpio_mask_irq
    import gpio_mask_pkg::*;
#(
    parameter int unsigned LINES      = GPIO_LINES_DEF,
    parameter int unsigned OD_LINES   = OD_LINES_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [2*LINES-1:0] bus_wdata,
    output logic [2*LINES-1:0] bus_rdata,
    input  logic [LINES-1:0]   pin_in,
    output logic [LINES-1:0]   pad_o,
    output logic [LINES-1:0]   pad_oe,
    output logic               chg_irq
);
    localparam int unsigned REG_W = 2 * LINES;

    logic [LINES-1:0] in_sync;
    logic [LINES-1:0] out_drive;

    gpio_in_sync #(.WIDTH(LINES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(in_sync)
    );

    gpio_chg_det #(.WIDTH(LINES), .DEPTH(SYNC_DEPTH)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_in(in_sync), .chg_pulse(chg_irq)
    );

    gpio_out_reg #(.WIDTH(LINES)) u_out (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr),
        .chg_mask(bus_wdata[REG_W-1:LINES]), .new_val(bus_wdata[LINES-1:0]),
        .drive(out_drive)
    );

    gpio_pad_ctrl #(.WIDTH(LINES), .OD_LINES(OD_LINES)) u_pad (
        .drive(out_drive), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    assign bus_rdata = {in_sync, out_drive};
endmodule

// File: rtl/gpio_mask_irq_chk.sv
`timescale 1ns/1ps
module gpio_mask_irq_chk #(
    parameter int unsigned LINES      = 16,
    parameter int unsigned OD_LINES   = 2,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [2*LINES-1:0] bus_wdata,
    input logic [2*LINES-1:0] bus_rdata,
    input logic [LINES-1:0]   pad_o,
    input logic [LINES-1:0]   pad_oe,
    input logic               chg_irq
);
    localparam int unsigned REG_W = 2 * LINES;
    localparam int unsigned FILL  = SYNC_DEPTH + 1;

    int unsigned cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= 0;
        else if (cyc_q < FILL) cyc_q <= cyc_q + 1;
    end

    assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> (bus_rdata[LINES-1:0] == $past(bus_rdata[LINES-1:0])));

    assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (((bus_rdata[LINES-1:0] ^ $past(bus_rdata[LINES-1:0]))
                     & ~$past(bus_wdata[REG_W-1:LINES])) == '0));

    assert_enabled_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (((bus_rdata[LINES-1:0] ^ $past(bus_wdata[LINES-1:0]))
                     & $past(bus_wdata[REG_W-1:LINES])) == '0));

    assert_irq_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= FILL) |->
        (chg_irq == (bus_rdata[REG_W-1:LINES] != $past(bus_rdata[REG_W-1:LINES]))));

    assert_quiet_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < FILL) |-> !chg_irq);

    assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o[OD_LINES-1:0] == '0) && (pad_oe[OD_LINES-1:0] == ~bus_rdata[OD_LINES-1:0]));

    assert_push_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&pad_oe[LINES-1:OD_LINES]) && (pad_o[LINES-1:OD_LINES] == bus_rdata[LINES-1:OD_LINES]));
endmodule

bind gpio_mask_irq gpio_mask_irq_chk #(
    .LINES(LINES), .OD_LINES(OD_LINES), .SYNC_DEPTH(SYNC_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_o(pad_o), .pad_oe(pad_oe), .chg_irq(chg_irq)
);

// File: tb/gpio_mask_irq_bench.sv
`timescale 1ns/1ps
module gpio_mask_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = 16'hA5C3;
    logic [15:0] pad_o, pad_oe;
    logic        chg_irq;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_out = 16'hFFFF;
    logic [31:0] lf = 32'h1D87_2B59;

    always #5 clk = ~clk;

    gpio_mask_irq u_gpio_mask_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pad_o(pad_o),
        .pad_oe(pad_oe), .chg_irq(chg_irq)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Output half and pads, computed from the expected output word.
    task automatic chk_outputs(input string req);
        logic [15:0] eo, eoe;
        eoe = {14'h3FFF, ~exp_out[1:0]};
        eo  = {exp_out[15:2], 2'b00};
        chk(bus_rdata[15:0] == exp_out, req, "output half", {16'h0, bus_rdata[15:0]}, {16'h0, exp_out});
        chk(pad_oe == eoe, "R8/R9", "pad_oe", {16'h0, pad_oe}, {16'h0, eoe});
        chk(pad_o == eo, "R8/R9", "pad_o", {16'h0, pad_o}, {16'h0, eo});
    endtask

    task automatic do_write(input logic [31:0] w, input string req);
        bus_wr    = 1'b1;
        bus_wdata = w;
        step();
        bus_wr = 1'b0;
        exp_out = (exp_out & ~w[31:16]) | (w[15:0] & w[31:16]);
        chk_outputs(req);
    endtask

    task automatic pin_change(input logic [15:0] nv, input string req);
        logic [15:0] old;
        old = pin_in;
        pin_in = nv;
        step();
        chk(bus_rdata[31:16] == old, "R5", "input after one edge", {16'h0, bus_rdata[31:16]}, {16'h0, old});
        chk(chg_irq == 1'b0, req, "irq early", {31'h0, chg_irq}, 32'h0);
        step();
        chk(bus_rdata[31:16] == nv, "R5", "input after two edges", {16'h0, bus_rdata[31:16]}, {16'h0, nv});
        chk(chg_irq == 1'b1, req, "irq pulse", {31'h0, chg_irq}, 32'h1);
        step();
        chk(chg_irq == 1'b0, req, "irq width", {31'h0, chg_irq}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: act=%h exp=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with nonzero pins
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_outputs("R1");
        chk(chg_irq == 1'b0, "R1", "irq in reset", {31'h0, chg_irq}, 32'h0);
        rst_n = 1'b1;
        // R7: no pulse while the synchroniser fills
        for (int k = 0; k < 6; k++) begin
            step();
            chk(chg_irq == 1'b0, "R7", "irq during fill", {31'h0, chg_irq}, 32'h0);
        end
        chk(bus_rdata[31:16] == 16'hA5C3, "R2", "input half", {16'h0, bus_rdata[31:16]}, 32'hA5C3);
        chk_outputs("R2");

        // R6: every line, both directions
        for (int i = 0; i < 16; i++) begin
            pin_change(pin_in ^ (16'h1 << i), "R6");
            pin_change(pin_in ^ (16'h1 << i), "R6");
        end
        // R6: many lines at once give one pulse
        pin_change(~pin_in, "R6");
        pin_change(16'h0000, "R6");

        // R7: steady inputs
        for (int k = 0; k < 8; k++) begin
            step();
            chk(chg_irq == 1'b0, "R7", "irq steady", {31'h0, chg_irq}, 32'h0);
        end

        // R3: single-bit clear and set of line 0
        do_write(32'h0001_0000, "R3");
        do_write(32'h0001_0001, "R3");
        // R3: empty mask changes nothing
        do_write(32'h0000_1234, "R3");
        // R3: pseudo-random masked writes
        for (int k = 0; k < 80; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_write(lf, "R3");
        end
        // R4: data on the bus without the strobe
        bus_wdata = 32'hFFFF_0000 ^ {16'h0, exp_out};
        for (int k = 0; k < 3; k++) begin
            step();
            chk_outputs("R4");
        end

        // R10/R8: release both open-drain lines, then pull them low from outside
        do_write(32'h0003_0003, "R8");
        chk(pad_oe[1:0] == 2'b00, "R8", "released oe", {30'h0, pad_oe[1:0]}, 32'h0);
        pin_change({pin_in[15:2], 2'b11}, "R6");
        pin_change({pin_in[15:2], 2'b00}, "R10");
        chk(bus_rdata[17:16] == 2'b00, "R10", "pad level read", {30'h0, bus_rdata[17:16]}, 32'h0);
        chk(bus_rdata[1:0] == 2'b11, "R10", "output bits kept", {30'h0, bus_rdata[1:0]}, 32'h3);
        do_write(32'h0003_0000, "R8");
        chk(pad_oe[1:0] == 2'b11, "R8", "pull low oe", {30'h0, pad_oe[1:0]}, 32'h3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule